// File: doc/BRIEF.md
# Smart-Card T=0 Character Transmitter

This block sends single bytes to a smart card over one shared, open-drain style I/O wire, using the character-oriented T=0 framing. The host presents a byte with a one-cycle start strobe. The block then drives a low start bit, the eight data bits least significant first, and an even parity bit. After that it lets go of the wire for two guard bit times, and in that window it listens for the card's error signal.

If the card holds the wire low at the sampling point, the block records a NACK. It sets a sticky flag, which reaches the interrupt output only when the enable input is set, and sends the same byte again straight after the guard window. A programmable limit bounds the number of resends. Once the limit is used up, the block gives up and pulses an abort strobe instead of a done strobe. A divisor sets the number of clock cycles in each bit time. The pad output enable is high only while the block is driving the wire.

Top module: `sc_t0_tx`

## Requirements
- R1: While not busy, io_out is 1 and io_oe is 0. An accepted start makes the frame begin in the next clock cycle. Each bit lasts cfg_div clock cycles. Frame bit 0 is the start bit and is 0. Bits 1 to 8 carry tx_data[0] to tx_data[7], in that order.
- R2: Frame bit 9 is the even parity bit, equal to the XOR of the eight data bits, so the nine bits together hold an even number of ones.
- R3: io_oe is 1 during frame bits 0 to 9. It is 0 during the two guard bits 10 and 11 and while idle. During the guard bits io_out is 1.
- R4: The block samples io_in in the last clock cycle of frame bit 10, which ends 11 bit times after the start edge. A low level there is a NACK. A high level there is an acknowledge.
- R5: Each NACK sets a sticky flag. nack_irq equals that flag ANDed with nack_ie. irq_clr clears the flag, but a NACK in the same cycle wins.
- R6: After a NACK, if the count of earlier NACKs in this character is below cfg_retry, the same byte is sent again. Its start bit begins in the cycle right after guard bit 11 ends.
- R7: If a NACK arrives when the earlier NACK count already equals cfg_retry, the character is dropped. tx_abort pulses for one cycle and tx_busy falls in that same cycle, with no resend. This makes cfg_retry+1 the maximum number of transmissions.
- R8: After an acknowledged frame, tx_done pulses for one cycle. This happens 12*cfg_div cycles after that frame's first cycle, and tx_busy falls in the same cycle. tx_done and tx_abort are never high together.
- R9: tx_start and tx_data are ignored while tx_busy is 1. Any resend carries the byte captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Clock cycles per bit time (0 is treated as 1) |
| cfg_retry | input | RETRY_W | Maximum number of resends after NACKs |
| nack_ie | input | 1 | Lets the NACK flag reach nack_irq |
| irq_clr | input | 1 | Clears the sticky NACK flag |
| tx_start | input | 1 | Start strobe, taken only when idle |
| tx_data | input | 8 | Byte to send |
| tx_busy | output | 1 | A character is in progress |
| tx_done | output | 1 | One-cycle pulse: character acknowledged |
| tx_abort | output | 1 | One-cycle pulse: retry limit exhausted |
| nack_irq | output | 1 | Gated NACK interrupt |
| io_in | input | 1 | Level of the shared I/O wire |
| io_out | output | 1 | Value driven onto the wire when enabled |
| io_oe | output | 1 | Pad output enable |

## Verification
The bench builds the block with DIV_W=8 and RETRY_W=2, and runs bit times of 3 and 4 clock cycles. With such short bit times, every check point inside a bit and every step of the frame counter can be reached within a few hundred cycles. The 2-bit retry field covers two cases cheaply. With a limit of 0, the first NACK aborts the character. With a limit of 2, both the last permitted resend and the first refused one are reached. A card model pulls the wire low across the sampling point, so the resend path, the gated interrupt and the abort path are all exercised at the pads.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;

  localparam int unsigned SC_DATA_W     = 8;
  localparam int unsigned SC_IDX_W      = 4;
  localparam int unsigned SC_DRIVEN     = 10;  // start + 8 data + parity
  localparam int unsigned SC_GUARD      = 2;
  localparam int unsigned SC_FRAME_BITS = SC_DRIVEN + SC_GUARD;

  localparam logic [SC_IDX_W-1:0] SC_PARITY_IDX = SC_IDX_W'(SC_DRIVEN - 1);
  localparam logic [SC_IDX_W-1:0] SC_SAMPLE_IDX = SC_IDX_W'(SC_DRIVEN);
  localparam logic [SC_IDX_W-1:0] SC_LAST_IDX   = SC_IDX_W'(SC_FRAME_BITS - 1);

  // Even parity: XOR of the data byte.
  function automatic logic sc_even_parity(input logic [SC_DATA_W-1:0] d);
    return ^d;
  endfunction

  // Level carried by frame bit idx while the wire is driven.
  function automatic logic sc_frame_bit(input logic [SC_DATA_W-1:0] d,
                                        input logic [SC_IDX_W-1:0]  idx);
    logic [SC_IDX_W-1:0] k;
    k = idx - SC_IDX_W'(1);
    if (idx == '0)
      return 1'b0;
    else if (idx < SC_PARITY_IDX)
      return d[k[2:0]];
    else if (idx == SC_PARITY_IDX)
      return sc_even_parity(d);
    else
      return 1'b1;
  endfunction

  function automatic logic sc_driving(input logic [SC_IDX_W-1:0] idx);
    return idx < SC_IDX_W'(SC_DRIVEN);
  endfunction

endpackage

// File: rtl/sc_t0_etu.sv
module sc_t0_etu #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             etu_end
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  function automatic logic [DIV_W-1:0] last_count(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - {{(DIV_W-1){1'b0}}, 1'b1};
  endfunction

  assign last    = last_count(cfg_div);
  assign etu_end = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run || etu_end)
      cnt <= '0;
    else
      cnt <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
  end

endmodule

// File: rtl/sc_t0_seq.sv
module sc_t0_seq
  import sc_t0_pkg::*;
#(
  parameter int RETRY_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SC_DATA_W-1:0] data,
  input  logic [RETRY_W-1:0]   retry_lim,
  input  logic                 etu_end,
  input  logic                 io_in,
  output logic                 busy,
  output logic [SC_IDX_W-1:0]  bit_idx,
  output logic [SC_DATA_W-1:0] hold_data,
  output logic [RETRY_W-1:0]   nack_cnt,
  output logic                 io_out,
  output logic                 io_oe,
  output logic                 nack_pulse,
  output logic                 done_pulse,
  output logic                 abort_pulse
);

  logic nacked;
  logic at_sample;
  logic at_last;

  assign at_sample  = busy && etu_end && (bit_idx == SC_SAMPLE_IDX);
  assign at_last    = busy && etu_end && (bit_idx == SC_LAST_IDX);
  assign nack_pulse = at_sample && !io_in;

  assign io_oe  = busy && sc_driving(bit_idx);
  assign io_out = io_oe ? sc_frame_bit(hold_data, bit_idx) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      bit_idx     <= '0;
      hold_data   <= '0;
      nack_cnt    <= '0;
      nacked      <= 1'b0;
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          bit_idx   <= '0;
          hold_data <= data;
          nack_cnt  <= '0;
          nacked    <= 1'b0;
        end
      end else if (etu_end) begin
        if (at_sample)
          nacked <= !io_in;
        if (at_last) begin
          if (!nacked) begin
            busy       <= 1'b0;
            done_pulse <= 1'b1;
          end else if (nack_cnt == retry_lim) begin
            busy        <= 1'b0;
            abort_pulse <= 1'b1;
          end else begin
            nack_cnt <= nack_cnt + {{(RETRY_W-1){1'b0}}, 1'b1};
            bit_idx  <= '0;
            nacked   <= 1'b0;
          end
        end else begin
          bit_idx <= bit_idx + SC_IDX_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
  import sc_t0_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [RETRY_W-1:0] cfg_retry,
  input  logic               nack_ie,
  input  logic               irq_clr,
  input  logic               tx_start,
  input  logic [7:0]         tx_data,
  output logic               tx_busy,
  output logic               tx_done,
  output logic               tx_abort,
  output logic               nack_irq,
  input  logic               io_in,
  output logic               io_out,
  output logic               io_oe
);

  logic                 etu_end;
  logic [SC_IDX_W-1:0]  bit_idx;
  logic [SC_DATA_W-1:0] hold_data;
  logic [RETRY_W-1:0]   nack_cnt;
  logic                 nack_pulse;
  logic                 nack_flag;

  sc_t0_etu #(.DIV_W(DIV_W)) u_etu (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tx_busy),
    .cfg_div (cfg_div),
    .etu_end (etu_end)
  );

  sc_t0_seq #(.RETRY_W(RETRY_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (tx_start),
    .data        (tx_data),
    .retry_lim   (cfg_retry),
    .etu_end     (etu_end),
    .io_in       (io_in),
    .busy        (tx_busy),
    .bit_idx     (bit_idx),
    .hold_data   (hold_data),
    .nack_cnt    (nack_cnt),
    .io_out      (io_out),
    .io_oe       (io_oe),
    .nack_pulse  (nack_pulse),
    .done_pulse  (tx_done),
    .abort_pulse (tx_abort)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      nack_flag <= 1'b0;
    else if (nack_pulse)
      nack_flag <= 1'b1;
    else if (irq_clr)
      nack_flag <= 1'b0;
  end

  assign nack_irq = nack_flag && nack_ie;

endmodule

// File: rtl/sc_t0_tx_chk.sv
module sc_t0_tx_chk #(
  parameter int RETRY_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_busy,
  input logic               tx_done,
  input logic               tx_abort,
  input logic               io_out,
  input logic               io_oe,
  input logic               nack_irq,
  input logic               nack_ie,
  input logic [3:0]         bit_idx,
  input logic               nack_pulse,
  input logic               nack_flag,
  input logic [7:0]         hold_data,
  input logic [RETRY_W-1:0] nack_cnt,
  input logic [RETRY_W-1:0] cfg_retry
);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (io_out && !io_oe));

  assert_guard_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && bit_idx >= 4'd10) |-> (!io_oe && io_out));

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nack_irq |-> nack_ie);

  assert_nack_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nack_pulse |=> nack_flag);

  assert_abort_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> ($past(nack_cnt) == $past(cfg_retry) && !tx_busy));

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $fell(tx_busy));

  assert_done_abort_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && tx_abort));

  assert_byte_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(hold_data));

endmodule

bind sc_t0_tx sc_t0_tx_chk #(.RETRY_W(RETRY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_busy    (tx_busy),
  .tx_done    (tx_done),
  .tx_abort   (tx_abort),
  .io_out     (io_out),
  .io_oe      (io_oe),
  .nack_irq   (nack_irq),
  .nack_ie    (nack_ie),
  .bit_idx    (bit_idx),
  .nack_pulse (nack_pulse),
  .nack_flag  (nack_flag),
  .hold_data  (hold_data),
  .nack_cnt   (nack_cnt),
  .cfg_retry  (cfg_retry)
);

// File: tb/sc_t0_tx_test.sv
`timescale 1ns/1ps
module sc_t0_tx_test;

  localparam int DIV_W   = 8;
  localparam int RETRY_W = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [DIV_W-1:0]   cfg_div = 8'd4;
  logic [RETRY_W-1:0] cfg_retry = '0;
  logic               nack_ie = 1'b0;
  logic               irq_clr = 1'b0;
  logic               tx_start = 1'b0;
  logic [7:0]         tx_data = '0;
  logic               tx_busy, tx_done, tx_abort, nack_irq;
  logic               io_out, io_oe, io_in;
  logic               card_pull = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  // Shared wire: the block drives when enabled, otherwise the card may pull low.
  assign io_in = io_oe ? io_out : !card_pull;

  sc_t0_tx #(.DIV_W(DIV_W), .RETRY_W(RETRY_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_retry(cfg_retry),
    .nack_ie(nack_ie), .irq_clr(irq_clr), .tx_start(tx_start), .tx_data(tx_data),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_abort(tx_abort), .nack_irq(nack_irq),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_bit(input logic [7:0] d, input int k);
    if (k == 0) return 0;
    if (k <= 8) return int'(d[k-1]);
    if (k == 9) return $countones(d) % 2;
    return 1;
  endfunction

  // Sends one character and follows it bit by bit. The card NACKs the first n_nack transmissions.
  task automatic run_char(input logic [7:0] d, input int div, input int lim,
                          input int n_nack, input bit ie, input bit poke);
    int sends;
    bit abort_exp;
    cfg_div   = DIV_W'(div);
    cfg_retry = RETRY_W'(lim);
    nack_ie   = ie;
    abort_exp = (n_nack > lim);
    sends     = abort_exp ? lim + 1 : n_nack + 1;
    @(negedge clk);
    tx_start = 1'b1;
    tx_data  = d;
    @(posedge clk); #1;
    tx_start = 1'b0;
    tx_data  = ~d;
    for (int a = 0; a < sends; a++) begin
      for (int c = 0; c < 12 * div; c++) begin
        int k, off;
        k   = c / div;
        off = c % div;
        card_pull = (a < n_nack) &&
                    ((k == 10 && off >= div / 2) || (k == 11 && off < div / 2));
        if (poke && a == 0 && c == 2) begin
          tx_start = 1'b1;        // R9: must be ignored while busy
          tx_data  = 8'h3C;
        end else begin
          tx_start = 1'b0;
        end
        if (off == div / 2) begin
          if (k <= 9) begin
            check("R3", "oe driven bit", int'(io_oe), 1);
            check(k == 9 ? "R2" : (a > 0 ? "R6" : "R1"), "frame bit", int'(io_out), ref_bit(d, k));
          end else begin
            check("R3", "oe guard bit", int'(io_oe), 0);
            check("R3", "out guard bit", int'(io_out), 1);
          end
          check("R8", "busy in frame", int'(tx_busy), 1);
        end
        @(posedge clk); #1;
      end
    end
    card_pull = 1'b0;
    tx_start  = 1'b0;
    check(abort_exp ? "R7" : "R8", "done pulse", int'(tx_done), abort_exp ? 0 : 1);
    check(abort_exp ? "R7" : "R8", "abort pulse", int'(tx_abort), abort_exp ? 1 : 0);
    check("R8", "busy at end", int'(tx_busy), 0);
    check("R4", "nack irq", int'(nack_irq), (ie && n_nack > 0) ? 1 : 0);
    @(posedge clk); #1;
    check("R8", "done one cycle", int'(tx_done), 0);
    check("R7", "abort one cycle", int'(tx_abort), 0);
    check("R1", "idle oe", int'(io_oe), 0);
  endtask

  task automatic clear_flag();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic test_reset();
    check("R1", "reset busy", int'(tx_busy), 0);
    check("R1", "reset oe", int'(io_oe), 0);
    check("R1", "reset out", int'(io_out), 1);
    check("R5", "reset irq", int'(nack_irq), 0);
    check("R8", "reset done", int'(tx_done), 0);
  endtask

  task automatic test_clean();
    run_char(8'hA5, 4, 2, 0, 1'b1, 1'b0);   // R1 R2: parity 0
    run_char(8'h01, 3, 2, 0, 1'b1, 1'b0);   // R2: parity 1
    run_char(8'hFE, 4, 0, 0, 1'b1, 1'b0);
  endtask

  task automatic test_resend();
    run_char(8'h96, 4, 2, 1, 1'b1, 1'b1);   // R4 R6 R9
    clear_flag();
    check("R5", "irq cleared", int'(nack_irq), 0);
    run_char(8'h5B, 3, 2, 2, 1'b1, 1'b0);   // R6: last permitted resend
    clear_flag();
  endtask

  task automatic test_irq_gate();
    run_char(8'h71, 4, 1, 1, 1'b0, 1'b0);
    check("R5", "gated irq low", int'(nack_irq), 0);
    @(negedge clk); nack_ie = 1'b1; #1;
    check("R5", "flag held, irq on enable", int'(nack_irq), 1);
    clear_flag(); #1;
    check("R5", "irq after clear", int'(nack_irq), 0);
  endtask

  task automatic test_abort();
    run_char(8'hC3, 4, 0, 1, 1'b1, 1'b0);   // R7: limit 0
    clear_flag();
    run_char(8'h2D, 3, 2, 3, 1'b1, 1'b0);   // R7: limit 2 exceeded
    clear_flag();
    run_char(8'h0F, 4, 1, 0, 1'b0, 1'b0);   // recovers after abort
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    test_clean();
    test_resend();
    test_irq_gate();
    test_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule